// File: doc/BRIEF.md
# Round-Robin Replicated Lane Array

This block takes one data word per clock cycle and spreads consecutive words over a set of identical processing lanes in strict rotation. Each lane owns one input register that is written only when the rotation reaches it, which happens once every `NUM_LANES` cycles. The lane's combinational function, a multiply-then-add placeholder, therefore has a window of `NUM_LANES` full clock periods to settle. A rotating output multiplexer collects each lane's result as that lane comes up for reloading. This returns the results at the full input rate, in the order the words arrived.

The lane load enables form a one-hot vector that a modulo counter advances every cycle. They stand in for per-lane divided clocks, and no clock is gated. A per-word valid bit travels with each word through its lane, so a gap in the input stream reappears as a gap at the output in the same slot. Latency is `NUM_LANES` cycles, compared with one cycle for a single-unit design.

Top module: `rr_lane_array`

## Requirements
- R1: While `rst_n` is low and after reset, `out_valid` is 0 and `out_data` is 0 until the first result is delivered.
- R2: Counting clock edges from reset release, starting at 0, the word sampled at edge k is written into lane k mod NUM_LANES. Exactly one lane load enable is active in every cycle, and after the last lane the rotation wraps to lane 0.
- R3: A lane's input register keeps its value in every cycle in which its load enable is inactive, giving the lane function a hold window of NUM_LANES cycles.
- R4: A valid word x sampled at edge k gives `out_data` = (x*MUL_K + ADD_K) mod 2^DATA_W, visible after edge k+NUM_LANES. With the defaults this is (3x+5) mod 256.
- R5: `out_valid` stays 0 for the first NUM_LANES cycles after reset release.
- R6: After edge k+NUM_LANES, `out_valid` equals the `in_valid` sampled at edge k. Gaps in the input are therefore kept in place, and output order equals input order.
- R7: A cycle in which `out_valid` is 0 leaves `out_data` at its previous value.
- R8: Asserting reset in the middle of a stream discards every word in flight. No result of an earlier word appears after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | Result qualifier |
| out_data | output | DATA_W | Result word |

## Verification
The main function is driven with an unbroken stream of distinct words. A word landing in the wrong lane, or a misaligned read-out, shows up as a reordered result. The stream then contains isolated and back-to-back gaps, which separate correct bubble placement from a valid bit that drifts to a neighbouring slot, and also show whether `out_data` holds during a gap. The extremes 0 and 255 test the truncation of the multiply-add, and a reset in mid-stream shows whether in-flight words are flushed.

// File: rtl/rr_lane_pkg.sv
package rr_lane_pkg;
  function automatic logic [63:0] lane_mul_add(input logic [63:0] x,
                                               input logic [63:0] k,
                                               input logic [63:0] c);
    return (x * k) + c;
  endfunction
endpackage

// File: rtl/rr_lane_rotor.sv
module rr_lane_rotor #(
  parameter int NUM_LANES = 4,
  localparam int IW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [IW-1:0]        idx,
  output logic [NUM_LANES-1:0] ld_en
);
  localparam logic [IW-1:0] LAST = IW'(NUM_LANES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)           idx <= '0;
    else if (idx == LAST) idx <= '0;
    else                  idx <= idx + 1'b1;
  end

  always_comb begin
    ld_en      = '0;
    ld_en[idx] = 1'b1;
  end
endmodule

// File: rtl/rr_lane_unit.sv
module rr_lane_unit #(
  parameter int DATA_W = 8,
  parameter int MUL_K  = 3,
  parameter int ADD_K  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] q_data,
  output logic              q_vld,
  output logic [DATA_W-1:0] res
);
  import rr_lane_pkg::*;

  logic [63:0] wide_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_data <= '0;
      q_vld  <= 1'b0;
    end else if (ld) begin
      q_vld <= in_valid;
      if (in_valid) q_data <= in_data;
    end
  end

  // Multicycle path: q_data is stable for NUM_LANES cycles before use.
  assign wide_res = lane_mul_add(64'(q_data), 64'(MUL_K), 64'(ADD_K));
  assign res      = wide_res[DATA_W-1:0];
endmodule

// File: rtl/rr_lane_array.sv
module rr_lane_array #(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 8,
  parameter int MUL_K     = 3,
  parameter int ADD_K     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int IW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic [IW-1:0]            rd_idx;
  logic [NUM_LANES-1:0]     ld_en;
  logic [NUM_LANES-1:0]     lane_vld;
  logic [DATA_W-1:0]        lane_res [NUM_LANES];
  logic [NUM_LANES*DATA_W-1:0] lane_q_flat;
  logic                     sel_vld;
  logic [DATA_W-1:0]        sel_res;

  rr_lane_rotor #(.NUM_LANES(NUM_LANES)) u_rotor (
    .clk(clk), .rst_n(rst_n), .idx(rd_idx), .ld_en(ld_en)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    rr_lane_unit #(.DATA_W(DATA_W), .MUL_K(MUL_K), .ADD_K(ADD_K)) u_unit (
      .clk(clk), .rst_n(rst_n), .ld(ld_en[g]),
      .in_valid(in_valid), .in_data(in_data),
      .q_data(lane_q_flat[g*DATA_W +: DATA_W]),
      .q_vld(lane_vld[g]), .res(lane_res[g])
    );
  end

  // The lane being reloaded this cycle was loaded NUM_LANES cycles ago:
  // read its result out on the same edge that overwrites its input.
  assign sel_vld = lane_vld[rd_idx];
  assign sel_res = lane_res[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= sel_vld;
      if (sel_vld) out_data <= sel_res;
    end
  end
endmodule

// File: rtl/rr_lane_array_chk.sv
module rr_lane_array_chk #(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 8,
  localparam int IW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int CW = $clog2(NUM_LANES + 2) + 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [IW-1:0]               rd_idx,
  input logic [NUM_LANES-1:0]        ld_en,
  input logic [NUM_LANES*DATA_W-1:0] lane_q_flat,
  input logic                        out_valid,
  input logic [DATA_W-1:0]           out_data
);
  logic [CW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n)                        since_rst <= '0;
    else if (since_rst <= CW'(NUM_LANES)) since_rst <= since_rst + 1'b1;
  end

  AST_ONE_LOADER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ld_en) == 1); // R2

  AST_ROTOR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == IW'(NUM_LANES - 1)) |=> (rd_idx == '0)); // R2

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst <= CW'(NUM_LANES)) |-> !out_valid); // R5

  AST_BUBBLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data) || !$past(rst_n)); // R7

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_hold
    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en[g] |=> $stable(lane_q_flat[g*DATA_W +: DATA_W])); // R3
  end
endmodule

bind rr_lane_array rr_lane_array_chk #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .ld_en(ld_en),
  .lane_q_flat(lane_q_flat), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/rr_lane_array_bench.sv
`timescale 1ns/1ps
module rr_lane_array_bench;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int NV = 20;
  // {valid, data}
  localparam logic [8:0] VEC [NV] = '{
    9'h101, 9'h102, 9'h103, 9'h104, 9'h1A0, 9'h155, 9'h1FF, 9'h100,
    9'h010, 9'h177, 9'h011, 9'h012, 9'h188, 9'h199, 9'h1AA, 9'h1BB,
    9'h013, 9'h1C3, 9'h17E, 9'h180
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic [DW-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  int t      = 0;
  logic          hv [0:255];
  logic [DW-1:0] hd [0:255];
  logic [DW-1:0] exp_data = '0;

  always #2 clk = ~clk;

  rr_lane_array #(.NUM_LANES(N), .DATA_W(DW)) u_rr_lane_array (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [DW-1:0] model(input logic [DW-1:0] d);
    logic [15:0] s;
    s = {8'h0, d} + {7'h0, d, 1'b0} + 16'd5;
    return s[DW-1:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", req, t, act, exp);
    end
  endtask

  // At the negedge before driving word t, the output reflects word t-1-N.
  task automatic step(input logic v, input logic [DW-1:0] d);
    int j;
    @(negedge clk);
    j = t - 1 - N;
    if (j >= 0) begin
      if (hv[j]) exp_data = hd[j];
      chk("R6 out_valid", 32'(out_valid), 32'(hv[j]));
      if (hv[j]) chk("R2 R4 out_data", 32'(out_data), 32'(exp_data));
      else       chk("R7 held data", 32'(out_data), 32'(exp_data));
    end else if (t > 0) begin
      chk("R5 early valid", 32'(out_valid), 32'd0);
    end
    in_valid = v;
    in_data  = d;
    hv[t] = v;
    hd[t] = model(d);
    t++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset valid", 32'(out_valid), 32'd0);
    chk("R1 reset data", 32'(out_data), 32'd0);
    rst_n = 1'b1;
    t = 0;
    exp_data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++) step(VEC[i][8], VEC[i][7:0]);
    for (int i = 0; i < N + 2; i++) step(1'b0, 8'h00);

    // R4 corner values: wrap of the multiply-add
    chk("R4 model 255", 32'(model(8'hFF)), 32'd2);
    step(1'b1, 8'hFF);
    step(1'b1, 8'h00);
    step(1'b1, 8'h80);
    for (int i = 0; i < N + 1; i++) step(1'b0, 8'h00);

    // R8: reset while words are in flight
    step(1'b1, 8'h21);
    step(1'b1, 8'h22);
    step(1'b1, 8'h23);
    do_reset();
    for (int i = 0; i < N + 2; i++) step(1'b0, 8'h00);
    chk("R8 flushed data", 32'(out_data), 32'd0);
    for (int i = 0; i < 2 * N; i++) step(1'b1, 8'(8'h30 + i));
    for (int i = 0; i < N + 1; i++) step(1'b0, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule